// File: doc/BRIEF.md
# Dual-Half Hamming ECC Generator

This block computes a single-error-correcting Hamming parity code over a 512-byte NAND sector. It watches the bytes moving through the NAND data path and accumulates a code for each 256-byte half of the sector separately. Each half gets 16 line-parity bits and 6 column-parity bits. With one code per half, the host can correct one flipped bit in each half independently. It does so by comparing a stored code with a freshly computed one.

The host drives the block with byte-wide commands written to the mode register. One command clears the accumulators and the byte counter. A second enables accumulation while data moves. A third turns data-register reads into result reads. A fourth returns the path to plain data transfer. After the clear command, the host performs one dummy data read before it enables calculation, and that read must not disturb the code.

In result mode the six code bytes come out as three 16-bit words in a fixed interleaved order. Every stored bit is inverted, so an erased sector of all 0xFF bytes produces an all-ones code.

Top module: `ecc_dual_half_gen`

## Requirements
- R1: After reset, `ecc_valid` is 0, `ecc_word` is 0x0000, the accumulators are cleared and the word pointer is at word 0. An immediate switch to result mode therefore yields 0xFFFF in all three words.
- R2: A mode write of 0xF4 clears both halves' accumulators, the byte counter and the word pointer, effective from the next clock edge.
- R3: A byte with `byte_vld` high is accumulated only while the mode is 0xB4 (calculate). In clear, result and data modes, bytes are ignored. This includes the dummy read performed after a clear.
- R4: Accumulated bytes 0 to 255 after a clear feed the first half, and bytes 256 to 511 feed the second half. Any byte beyond the 512th is ignored.
- R5: For a byte at index i (0 to 255) within its half, with overall XOR parity p, line parity bit 2k+1 toggles by p when bit k of i is 1. Line parity bit 2k toggles by p when bit k of i is 0 (k = 0 to 7).
- R6: The column parities of a half are the XOR over all its bytes of these bit groups: CP0 = bits 0,2,4,6; CP1 = bits 1,3,5,7; CP2 = bits 0,1,4,5; CP3 = bits 2,3,6,7; CP4 = bits 0 to 3; CP5 = bits 4 to 7.
- R7: All code bits are output inverted. The column byte of a half is {~CP5..~CP0, 2'b11}, so its two low bits always read 1.
- R8: A mode write of 0xD4 sets `ecc_valid`. Each `word_rd` pulse in result mode advances the pointer 0 to 1 to 2 and then wraps back to 0.
- R9: Word 0 is {~LPa[15:8], ~LPa[7:0]}. Word 1 is {~LPb[7:0], column byte a}. Word 2 is {column byte b, ~LPb[15:8]}. Here a is the first half and b is the second half.
- R10: Any mode write other than 0xF4, 0xB4 and 0xD4, including 0x94, selects data mode. In data mode `ecc_valid` is 0, `ecc_word` is 0, and the accumulators keep their values for a later readout.
- R11: A `word_rd` pulse outside result mode leaves the word pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_val | input | 8 | Mode command byte |
| byte_vld | input | 1 | A data byte is passing through the NAND path this cycle |
| byte_in | input | 8 | The snooped data byte |
| word_rd | input | 1 | Host read of the data register (advances result pointer in result mode) |
| ecc_valid | output | 1 | Result mode is active |
| ecc_word | output | 16 | Current result word, 0 outside result mode |

## Verification
The assertions assume that the host sends one command per cycle and never writes a mode in the same cycle as it reads a word it relies on. They also assume that `byte_vld` and `word_rd` are single-cycle strobes that are meaningful only in the modes described above. The stimulus follows the host's order: clear, dummy read and stray bytes in clear mode, calculate, a byte stream, result, three reads, then data mode. Byte counts of 100, 257, 512 and 600 cover both halves, the half boundary and the overflow cut-off. Commands and reads are driven on the falling edge so each arrives as a clean one-cycle pulse.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  typedef enum logic [1:0] {
    MD_DATA   = 2'd0,
    MD_CLEAR  = 2'd1,
    MD_CALC   = 2'd2,
    MD_RESULT = 2'd3
  } ecc_mode_e;

  localparam int CP_W = 6;

  // overall parity of a byte
  function automatic logic byte_par(input logic [7:0] b);
    return ^b;
  endfunction

  // column group parities, result bit n is CPn
  function automatic logic [CP_W-1:0] col_par(input logic [7:0] b);
    logic [CP_W-1:0] c;
    c[0] = ^(b & 8'h55);
    c[1] = ^(b & 8'hAA);
    c[2] = ^(b & 8'h33);
    c[3] = ^(b & 8'hCC);
    c[4] = ^(b & 8'h0F);
    c[5] = ^(b & 8'hF0);
    return c;
  endfunction

  // stored column byte: inverted parities with two padding ones
  function automatic logic [7:0] col_byte(input logic [CP_W-1:0] cp);
    return {~cp, 2'b11};
  endfunction

endpackage

// File: rtl/ecc_half_acc.sv
module ecc_half_acc
  import ecc_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic [IDX_W-1:0]     idx,
  input  logic [7:0]           din,
  output logic [2*IDX_W-1:0]   lp_o,
  output logic [CP_W-1:0]      cp_o
);
  localparam int LP_W = 2 * IDX_W;

  // line parity toggle mask for one byte at index ix with parity p
  function automatic logic [LP_W-1:0] line_mask(input logic [IDX_W-1:0] ix,
                                                input logic p);
    logic [LP_W-1:0] m;
    for (int k = 0; k < IDX_W; k++) begin
      m[2*k+1] = p & ix[k];
      m[2*k]   = p & ~ix[k];
    end
    return m;
  endfunction

  logic [LP_W-1:0] lp_q;
  logic [CP_W-1:0] cp_q;
  logic            din_par;

  assign din_par = byte_par(din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (clr) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (en) begin
      lp_q <= lp_q ^ line_mask(idx, din_par);
      cp_q <= cp_q ^ col_par(din);
    end
  end

  assign lp_o = lp_q;
  assign cp_o = cp_q;

  // R2
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (lp_q == '0) && (cp_q == '0));

  // R3
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> ($stable(lp_q) && $stable(cp_q)));

  // R5
  line_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !din_par) |=> $stable(lp_q));

endmodule

// File: rtl/ecc_cmd_ctrl.sv
module ecc_cmd_ctrl
  import ecc_pkg::*;
#(
  parameter int          IDX_W       = 8,
  parameter logic [7:0]  CODE_CLEAR  = 8'hF4,
  parameter logic [7:0]  CODE_CALC   = 8'hB4,
  parameter logic [7:0]  CODE_RESULT = 8'hD4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [7:0]        mode_val,
  input  logic              byte_vld,
  input  logic              word_rd,
  output logic              clr_o,
  output logic [1:0]        half_en_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [1:0]        ptr_o,
  output logic              valid_o
);
  localparam int               CNT_W        = IDX_W + 2;
  localparam logic [CNT_W-1:0] SECTOR_BYTES = CNT_W'(2 << IDX_W);
  localparam logic [1:0]       LAST_WORD    = 2'd2;

  function automatic ecc_mode_e decode_mode(input logic [7:0] c);
    if (c == CODE_CLEAR)       return MD_CLEAR;
    else if (c == CODE_CALC)   return MD_CALC;
    else if (c == CODE_RESULT) return MD_RESULT;
    else                       return MD_DATA;
  endfunction

  ecc_mode_e        mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       ptr_q;

  // named events
  logic clr_cmd;
  logic acc_fire;
  logic word_adv;

  assign clr_cmd  = mode_wr && (mode_val == CODE_CLEAR);
  assign acc_fire = byte_vld && (mode_q == MD_CALC) && (cnt_q < SECTOR_BYTES);
  assign word_adv = word_rd && (mode_q == MD_RESULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MD_DATA;
    else if (mode_wr) mode_q <= decode_mode(mode_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr_cmd)  cnt_q <= '0;
    else if (acc_fire) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= '0;
    else if (clr_cmd)  ptr_q <= '0;
    else if (word_adv) ptr_q <= (ptr_q == LAST_WORD) ? 2'd0 : ptr_q + 2'd1;
  end

  assign clr_o     = clr_cmd;
  assign half_en_o = acc_fire ? (cnt_q[IDX_W] ? 2'b10 : 2'b01) : 2'b00;
  assign idx_o     = cnt_q[IDX_W-1:0];
  assign ptr_o     = ptr_q;
  assign valid_o   = (mode_q == MD_RESULT);

  // R4
  cnt_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SECTOR_BYTES);

  // R4
  cnt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == SECTOR_BYTES && !clr_cmd) |=> (cnt_q == SECTOR_BYTES));

  // R4
  half_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(half_en_o));

  // R8
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q != 2'd3);

  // R8
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_adv && ptr_q == LAST_WORD && !clr_cmd) |=> (ptr_q == 2'd0));

  // R11
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_rd && mode_q != MD_RESULT && !clr_cmd) |=> $stable(ptr_q));

  // R3
  calc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MD_CALC && !clr_cmd) |=> $stable(cnt_q));

endmodule

// File: rtl/ecc_result_mux.sv
module ecc_result_mux
  import ecc_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*IDX_W-1:0]  lp_a,
  input  logic [CP_W-1:0]     cp_a,
  input  logic [2*IDX_W-1:0]  lp_b,
  input  logic [CP_W-1:0]     cp_b,
  input  logic [1:0]          ptr,
  input  logic                valid,
  output logic [15:0]         word_o
);
  logic [7:0] col_a;
  logic [7:0] col_b;

  assign col_a = col_byte(cp_a);
  assign col_b = col_byte(cp_b);

  always_comb begin
    word_o = 16'h0000;
    if (valid) begin
      case (ptr)
        2'd0:    word_o = {~lp_a[15:8], ~lp_a[7:0]};
        2'd1:    word_o = {~lp_b[7:0], col_a};
        2'd2:    word_o = {col_b, ~lp_b[15:8]};
        default: word_o = 16'h0000;
      endcase
    end
  end

  // R7
  col_pad_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ptr == 2'd1) |-> (word_o[1:0] == 2'b11));

  // R7
  col_pad_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ptr == 2'd2) |-> (word_o[9:8] == 2'b11));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (word_o == 16'h0000));

endmodule

// File: rtl/ecc_dual_half_gen.sv
module ecc_dual_half_gen
  import ecc_pkg::*;
#(
  parameter int          IDX_W       = 8,
  parameter logic [7:0]  CODE_CLEAR  = 8'hF4,
  parameter logic [7:0]  CODE_CALC   = 8'hB4,
  parameter logic [7:0]  CODE_RESULT = 8'hD4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_wr,
  input  logic [7:0]  mode_val,
  input  logic        byte_vld,
  input  logic [7:0]  byte_in,
  input  logic        word_rd,
  output logic        ecc_valid,
  output logic [15:0] ecc_word
);
  localparam int LP_W   = 2 * IDX_W;
  localparam int HALVES = 2;

  logic              clr;
  logic [1:0]        half_en;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        ptr;
  logic [LP_W-1:0]   lp_arr [HALVES];
  logic [CP_W-1:0]   cp_arr [HALVES];

  ecc_cmd_ctrl #(
    .IDX_W(IDX_W), .CODE_CLEAR(CODE_CLEAR),
    .CODE_CALC(CODE_CALC), .CODE_RESULT(CODE_RESULT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .mode_wr(mode_wr), .mode_val(mode_val),
    .byte_vld(byte_vld), .word_rd(word_rd),
    .clr_o(clr), .half_en_o(half_en), .idx_o(idx),
    .ptr_o(ptr), .valid_o(ecc_valid)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    ecc_half_acc #(.IDX_W(IDX_W)) u_acc (
      .clk(clk), .rst_n(rst_n),
      .clr(clr), .en(half_en[h]),
      .idx(idx), .din(byte_in),
      .lp_o(lp_arr[h]), .cp_o(cp_arr[h])
    );
  end

  ecc_result_mux #(.IDX_W(IDX_W)) u_mux (
    .clk(clk), .rst_n(rst_n),
    .lp_a(lp_arr[0]), .cp_a(cp_arr[0]),
    .lp_b(lp_arr[1]), .cp_b(cp_arr[1]),
    .ptr(ptr), .valid(ecc_valid),
    .word_o(ecc_word)
  );

  // R8
  result_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_val == CODE_RESULT) |=> ecc_valid);

  // R10
  data_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_val != CODE_RESULT) |=> !ecc_valid);

endmodule

// File: tb/sim_ecc_dual_half_gen.sv
module sim_ecc_dual_half_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [7:0]  mode_val = 8'h00;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic        word_rd = 1'b0;
  logic        ecc_valid;
  logic [15:0] ecc_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0]  mem [0:511];
  logic [15:0] exp_w [0:2];

  always #10 clk = ~clk;

  ecc_dual_half_gen u0 (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_val(mode_val),
    .byte_vld(byte_vld), .byte_in(byte_in), .word_rd(word_rd),
    .ecc_valid(ecc_valid), .ecc_word(ecc_word)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // bitwise model: every set bit toggles its line and column parities
  task automatic model(input int n);
    logic [15:0] lp [2];
    logic [5:0]  cp [2];
    lp[0] = '0; lp[1] = '0; cp[0] = '0; cp[1] = '0;
    for (int i = 0; i < n && i < 512; i++) begin
      int h  = i / 256;
      int ix = i % 256;
      for (int b = 0; b < 8; b++) begin
        if (mem[i][b]) begin
          for (int k = 0; k < 8; k++) begin
            if ((ix >> k) & 1) lp[h][2*k+1] = ~lp[h][2*k+1];
            else               lp[h][2*k]   = ~lp[h][2*k];
          end
          if (b % 2 == 0)        cp[h][0] = ~cp[h][0];
          else                   cp[h][1] = ~cp[h][1];
          if (((b >> 1) & 1) == 0) cp[h][2] = ~cp[h][2];
          else                     cp[h][3] = ~cp[h][3];
          if (b < 4)             cp[h][4] = ~cp[h][4];
          else                   cp[h][5] = ~cp[h][5];
        end
      end
    end
    exp_w[0] = ~lp[0];
    exp_w[1] = {~lp[1][7:0], ~cp[0], 2'b11};
    exp_w[2] = {~cp[1], 2'b11, ~lp[1][15:8]};
  endtask

  task automatic put_mode(input logic [7:0] c);
    mode_wr = 1'b1; mode_val = c;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    byte_vld = 1'b1; byte_in = b;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic pulse_rd();
    word_rd = 1'b1;
    @(negedge clk);
    word_rd = 1'b0;
  endtask

  task automatic read_all(input string tag);
    for (int w = 0; w < 3; w++) begin
      check($sformatf("%s R9 word%0d", tag, w), ecc_word, exp_w[w]);
      pulse_rd();
    end
    check($sformatf("%s R8 wrap", tag), ecc_word, exp_w[0]);
  endtask

  // full host sequence over n bytes of mem
  task automatic run_sector(input string tag, input int n);
    put_mode(8'hF4);
    pulse_rd();          // dummy read, R3
    put_byte(8'h5A);     // stray byte in clear mode, R3
    put_mode(8'hB4);
    for (int i = 0; i < n; i++) put_byte(i < 512 ? mem[i] : 8'hA7);
    put_mode(8'hD4);
    check($sformatf("%s R8 valid", tag), {15'd0, ecc_valid}, 16'd1);
    model(n);
    read_all(tag);
    put_mode(8'h94);
    check($sformatf("%s R10 valid", tag), {15'd0, ecc_valid}, 16'd0);
    check($sformatf("%s R10 word", tag), ecc_word, 16'h0000);
  endtask

  task automatic t_reset();
    check("R1 valid", {15'd0, ecc_valid}, 16'd0);
    check("R1 word", ecc_word, 16'h0000);
    put_mode(8'hD4);
    exp_w[0] = 16'hFFFF; exp_w[1] = 16'hFFFF; exp_w[2] = 16'hFFFF;
    read_all("R1 fresh");
    put_mode(8'h94);
  endtask

  task automatic t_erased();
    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
    run_sector("R7 erased", 512);
  endtask

  task automatic t_single_flips();
    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
    mem[37]  = 8'hDF;
    mem[300] = 8'hFB;
    run_sector("R5 R6 flips", 512);
  endtask

  task automatic t_pseudo();
    logic [7:0] x = 8'h1D;
    for (int i = 0; i < 512; i++) begin
      mem[i] = x;
      x = {x[6:0], x[7] ^ x[5] ^ x[4] ^ x[3]};
    end
    run_sector("R5 R6 lfsr", 512);
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 7 + 3);
    run_sector("R5 R6 ramp", 512);
  endtask

  task automatic t_boundary();
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    mem[256] = 8'h01;
    run_sector("R4 boundary", 257);
    for (int i = 0; i < 512; i++) mem[i] = 8'(i ^ 8'h3C);
    run_sector("R4 partial", 100);
    run_sector("R4 overflow", 600);
  endtask

  task automatic t_retain();
    // after a sector in data mode, stray bytes must not change the code
    for (int i = 0; i < 20; i++) put_byte(8'h81);
    put_mode(8'hD4);
    read_all("R10 retain");
    put_mode(8'h94);
  endtask

  task automatic t_ptr_hold();
    for (int i = 0; i < 512; i++) mem[i] = 8'(i);
    model(512);
    put_mode(8'hF4);
    put_mode(8'hB4);
    for (int i = 0; i < 512; i++) put_byte(mem[i]);
    put_mode(8'hD4);
    check("R11 word0", ecc_word, exp_w[0]);
    pulse_rd();
    put_mode(8'h94);
    pulse_rd();
    pulse_rd();
    put_mode(8'hD4);
    check("R11 held at word1", ecc_word, exp_w[1]);
    put_mode(8'hF4);
    put_mode(8'hD4);
    check("R2 cleared", ecc_word, 16'hFFFF);
    pulse_rd();
    check("R2 cleared w1", ecc_word, 16'hFFFF);
    put_mode(8'h94);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_erased();
    t_single_flips();
    t_pseudo();
    t_boundary();
    t_retain();
    t_ptr_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule